// File: doc/BRIEF.md
# Indexed Clock-Chip Register Bank

This block is the register file behind a small real-time clock. Software reaches it through two byte addresses. A write to the even address selects one of 128 byte locations. Reads and writes at the odd address then access the selected byte. Most locations are plain storage, including the time and alarm bytes that a separate calendar engine maintains. Four locations are control and status bytes with special rules:

- a rate/status byte at index 10, whose top bit is a read-only update-in-progress flag;
- a mode byte at index 11;
- an interrupt flag byte at index 12, which clears when it is read;
- a fixed status byte at index 13.

The calendar engine and the periodic rate generator connect through single-cycle strobes:

- update-begin;
- update-done;
- alarm match;
- periodic tick.

The bank turns these strobes into flag bits and an active-high interrupt request, using the enable bits in the mode byte. The rate/status and mode bytes are also driven out continuously, so the neighbouring engines can follow the selected modes.

Top module: `rtc_regbank`

## Requirements
- R1: A write to the even address (bus_addr=0) stores bus_wdata[6:0] as the index and ignores bit 7. A read of the even address returns 0xFF.
- R2: A write to the odd address at any index outside 10..13 stores the byte. A later odd read at that index returns it. Every such byte is 0x00 after power-up reset.
- R3: At index 10, bit 7 is the update-in-progress flag and writes do not change it. A write to index 10 replaces bits 6:0 only.
- R4: Writes to index 12 and index 13 have no effect. Index 13 always reads 0x80.
- R5: A write to index 11 with bit 7 (SET) at 1 clears the update-in-progress flag. The same write stores bit 4 (update interrupt enable) as 0, whatever the data.
- R6: An odd read of index 12 returns the flag byte. The flag byte is then 0x00 and irq is low, unless a new event arrived in the same cycle.
- R7: An update-done strobe always sets bit 4 of index 12 and clears the update-in-progress flag. It sets bit 7 and raises irq only when bit 4 of index 11 is 1.
- R8: While bit 5 of index 11 is 1, an alarm-match strobe sets bits 5 and 7 of index 12. While bit 6 of index 11 is 1, a periodic tick sets bits 6 and 7. With its enable at 0, each strobe leaves index 12 and irq unchanged.
- R9: An update-begin strobe sets the update-in-progress flag only while SET (bit 7 of index 11) is 0.
- R10: After power-up reset: index 10 reads 0x26, index 11 reads 0x02, index 12 reads 0x00, index 13 reads 0x80, and irq is low. irq always equals bit 7 of index 12.
- R11: A sys_reset pulse clears bits 6, 5 and 3 of index 11. It also clears all of index 12 and lowers irq. It does not change the other bits of index 11.
- R12: When an odd read of index 12 coincides with an event strobe, the read returns the old flag byte. The new event's bits stay set afterwards, and irq follows the new bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| sys_reset | input | 1 | System reset pulse, clears enables and flags |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after a read |
| upd_begin | input | 1 | Calendar update starting |
| upd_done | input | 1 | Calendar update finished |
| alarm_match | input | 1 | Alarm comparison hit |
| periodic_tick | input | 1 | Periodic rate event |
| ctrl_a | output | 8 | Rate/status byte (index 10) |
| ctrl_b | output | 8 | Mode byte (index 11) |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench drives a read of the flag byte and an update-done strobe in the same cycle. A bank that clears the flags after merging would lose the new event and leave irq low. It writes the rate byte with the update-in-progress flag set. A design that let the write through would show the flag cleared, or set from the data. It writes the mode byte with SET and update-interrupt-enable both at 1. A wrong design would keep the enable, or leave update-in-progress set. Each strobe is also sent with its enable off, where a careless bank would raise irq.

// File: rtl/rtc_regbank.sv
module rtc_regbank (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_reset,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       upd_begin,
  input  logic       upd_done,
  input  logic       alarm_match,
  input  logic       periodic_tick,
  output logic [7:0] ctrl_a,
  output logic [7:0] ctrl_b,
  output logic       irq
);
  localparam int NREG = 128;
  localparam logic [6:0] IX_A = 7'd10, IX_B = 7'd11, IX_C = 7'd12, IX_D = 7'd13;
  localparam logic [7:0] B_CLR_ON_RST = 8'h68;

  logic [6:0] idx;
  logic [7:0] mem [NREG];
  logic       uip;
  logic [6:0] a_lo;
  logic [7:0] b_reg, c_reg;

  wire wr_idx  = bus_en & bus_we & ~bus_addr;
  wire wr_dat  = bus_en & bus_we & bus_addr;
  wire rd_any  = bus_en & ~bus_we;
  wire sel_a   = idx == IX_A;
  wire sel_b   = idx == IX_B;
  wire sel_c   = idx == IX_C;
  wire sel_d   = idx == IX_D;
  wire sel_mem = !(sel_a | sel_b | sel_c | sel_d);
  wire rd_c    = rd_any & bus_addr & sel_c;
  wire wr_bset = wr_dat & sel_b & bus_wdata[7];

  wire ev_pf = periodic_tick & b_reg[6];
  wire ev_af = alarm_match & b_reg[5];
  wire ev_ui = upd_done & b_reg[4];
  wire [7:0] new_flags = {ev_pf | ev_af | ev_ui, ev_pf, ev_af, upd_done, 4'h0};

  assign ctrl_a = {uip, a_lo};
  assign ctrl_b = b_reg;
  assign irq    = c_reg[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) idx <= '0;
    else if (wr_idx) idx <= bus_wdata[6:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_dat && sel_mem) mem[idx] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) a_lo <= 7'h26;
    else if (wr_dat && sel_a) a_lo <= bus_wdata[6:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) uip <= 1'b0;
    else if (wr_bset || upd_done) uip <= 1'b0;
    else if (upd_begin && !b_reg[7]) uip <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) b_reg <= 8'h02;
    else if (sys_reset) b_reg <= b_reg & ~B_CLR_ON_RST;
    else if (wr_dat && sel_b) b_reg <= bus_wdata[7] ? (bus_wdata & 8'hEF) : bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) c_reg <= '0;
    else if (sys_reset) c_reg <= '0;
    else c_reg <= (rd_c ? 8'h00 : c_reg) | new_flags;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (rd_any) begin
      if (!bus_addr)  bus_rdata <= 8'hFF;
      else if (sel_a) bus_rdata <= {uip, a_lo};
      else if (sel_b) bus_rdata <= b_reg;
      else if (sel_c) bus_rdata <= c_reg;
      else if (sel_d) bus_rdata <= 8'h80;
      else            bus_rdata <= mem[idx];
    end

  p_uip_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && sel_a && !upd_done && !upd_begin) |=> ctrl_a[7] == $past(ctrl_a[7]));

  p_set_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bset |=> (!ctrl_a[7] && !ctrl_b[4]));

  p_rdc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !upd_done && !alarm_match && !periodic_tick) |=> (c_reg == 8'h00 && !irq));

  p_uf_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && !sys_reset) |=> (c_reg[4] && !ctrl_a[7]));

  p_no_ui_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && !ctrl_b[4] && !irq && !alarm_match && !periodic_tick) |=> !irq);

  p_sysrst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |=> ((ctrl_b & B_CLR_ON_RST) == 8'h00 && !irq));

  p_survive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && upd_done && !sys_reset) |=> c_reg[4]);
endmodule

// File: tb/sim_rtc_regbank.sv
module sim_rtc_regbank;
  logic clk = 0, rst_n = 0, sys_reset = 0;
  logic bus_en = 0, bus_we = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, ctrl_a, ctrl_b;
  logic upd_begin = 0, upd_done = 0, alarm_match = 0, periodic_tick = 0;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] model [128];

  always #10 clk = ~clk;

  rtc_regbank u0 (.clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .upd_begin(upd_begin), .upd_done(upd_done), .alarm_match(alarm_match),
    .periodic_tick(periodic_tick), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .irq(irq));

  function automatic logic [7:0] exp_b_wr(input logic [7:0] d);
    return d[7] ? (d & 8'hEF) : d;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic wr(input logic [6:0] ix, input logic [7:0] d);
    acc(1, 0, {1'b0, ix});
    acc(1, 1, d);
  endtask

  task automatic rd(input logic [6:0] ix, output logic [7:0] d);
    acc(1, 0, {1'b0, ix});
    acc(0, 1, 8'h00);
    d = bus_rdata;
  endtask

  task automatic ev(input int k);
    @(negedge clk);
    case (k)
      0: upd_begin = 1;
      1: upd_done = 1;
      2: alarm_match = 1;
      3: periodic_tick = 1;
      default: sys_reset = 1;
    endcase
    @(negedge clk);
    upd_begin = 0; upd_done = 0; alarm_match = 0; periodic_tick = 0; sys_reset = 0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R10 irq", {7'h0, irq}, 8'h00);
    rd(10, v); check("R10 A", v, 8'h26);
    rd(11, v); check("R10 B", v, 8'h02);
    rd(12, v); check("R10 C", v, 8'h00);
    rd(13, v); check("R10 D", v, 8'h80);
    rd(40, v); check("R2 reset byte", v, 8'h00);

    acc(1, 0, 8'h8E); acc(1, 1, 8'h5A); model[14] = 8'h5A;
    acc(1, 0, 8'h0E); acc(0, 1, 0); check("R1 index bit7 ignored", bus_rdata, 8'h5A);
    acc(0, 0, 0); check("R1 even read", bus_rdata, 8'hFF);

    void'($urandom(32'h00C0FFEE));
    for (int n = 0; n < 300; n++) begin
      logic [6:0] ix;
      ix = 7'($urandom_range(0, 127));
      if (ix >= 10 && ix <= 13) ix = 7'd20;
      if ($urandom_range(0, 1) == 1) begin
        logic [7:0] d;
        d = 8'($urandom);
        wr(ix, d); model[ix] = d;
      end else begin
        rd(ix, v); check("R2 random readback", v, model[ix]);
      end
    end

    wr(10, 8'h00); rd(10, v); check("R3 A write", v, 8'h00);
    ev(0); rd(10, v); check("R9 uip set", v, 8'h80);
    wr(10, 8'h55); rd(10, v); check("R3 uip kept", v, 8'hD5);
    wr(10, 8'h7F); wr(10, 8'h55);
    ev(1); rd(10, v); check("R7 uip cleared", v, 8'h55);
    check("R7 no irq w/o UIE", {7'h0, irq}, 8'h00);
    rd(12, v); check("R7 UF only", v, 8'h10);
    ev(0); wr(11, 8'h92); rd(11, v); check("R5 UIE forced 0", v, exp_b_wr(8'h92));
    rd(10, v); check("R5 uip cleared", v, 8'h55);
    ev(0); rd(10, v); check("R9 no uip in SET", v, 8'h55);

    wr(12, 8'hFF); wr(13, 8'h00);
    rd(12, v); check("R4 C write ignored", v, 8'h00);
    rd(13, v); check("R4 D write ignored", v, 8'h80);

    wr(11, 8'h12); ev(1);
    check("R7 irq with UIE", {7'h0, irq}, 8'h01);
    rd(12, v); check("R7 IRQF|UF", v, 8'h90);
    check("R6 irq dropped", {7'h0, irq}, 8'h00);
    rd(12, v); check("R6 C cleared", v, 8'h00);

    wr(11, 8'h62);
    ev(2); rd(12, v); check("R8 alarm", v, 8'hA0);
    ev(3); rd(12, v); check("R8 periodic", v, 8'hC0);
    wr(11, 8'h02);
    ev(2); ev(3); check("R8 disabled irq", {7'h0, irq}, 8'h00);
    rd(12, v); check("R8 disabled flags", v, 8'h00);

    wr(11, 8'h12); acc(1, 0, 8'h0C);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = 1; upd_done = 1;
    @(negedge clk);
    bus_en = 0; upd_done = 0;
    check("R12 old value read", bus_rdata, 8'h00);
    check("R12 irq reasserted", {7'h0, irq}, 8'h01);
    rd(12, v); check("R12 flags survive", v, 8'h90);

    wr(11, 8'h6A); ev(2);
    check("R11 irq before", {7'h0, irq}, 8'h01);
    ev(4);
    check("R11 irq lowered", {7'h0, irq}, 8'h00);
    rd(11, v); check("R11 B masked", v, 8'h02);
    rd(12, v); check("R11 C cleared", v, 8'h00);
    summary();
  end
endmodule